// File: doc/BRIEF.md
# Classification action forwarding modifier

This block sits after the rule-matching stage of a switch ingress pipeline. It merges the action of a matched classification rule into the forwarding decision of a frame. It takes four inputs:

- the destination port map produced by address learning, indexed by physical port;
- the frame's current traffic class;
- a hit flag;
- the two action words read for the matched rule index.

It produces the final physical destination port map, the final traffic class, and an 8-bit classification ID. A later stage inserts that ID into the frame tag.

The action carries a 9-bit destination map whose bit positions skip physical port 6. A 2-bit mode chooses how that map combines with the learned map: keep the learned map, remove ports from it, replace it, or add ports to it. A separate flag decides whether a new traffic class overrides the frame's own. The final traffic class selects one of eight egress queues further down the pipeline.

All three outputs are registered, so they follow the inputs by one clock cycle. When the hit flag is low, the frame's own forwarding decision passes through untouched and the classification ID is zero.

Top module: `cfa_action_modifier`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `outMap`, `outTc` and `outClassId` are all zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge, with exactly one cycle of latency and no dependence on older inputs.
- R3: With `hitFlag` low, `outMap` equals `learnMap`, `outTc` equals `frameTc` and `outClassId` is 0, whatever the action words hold.
- R4: With a hit and mode field `actWord0[25:24]` = 0, `outMap` equals `learnMap`.
- R5: With a hit and mode 1, `outMap` equals `learnMap` with the ports of the expanded action map cleared.
- R6: With a hit and mode 2, `outMap` equals the expanded action map, so physical port 6 is always 0.
- R7: With a hit and mode 3, `outMap` is the bitwise OR of `learnMap` and the expanded action map.
- R8: The action map is `actWord0[22:14]`. Map bit n drives physical port n for n < 6 and physical port n+1 for n >= 6. No action map bit drives port 6.
- R9: With a hit and `actWord0[13]` = 1, `outTc` equals `actWord0[12:10]`. Otherwise `outTc` equals `frameTc`.
- R10: With a hit, `outClassId` equals `actWord1[27:20]`. All other bits of `actWord1` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hitFlag | input | 1 | A rule matched this frame |
| learnMap | input | 10 | Learned destination map, bit p = physical port p |
| frameTc | input | 3 | Traffic class of the frame |
| actWord0 | input | 32 | First action word: map, mode, traffic-class override |
| actWord1 | input | 32 | Second action word: classification ID |
| outMap | output | 10 | Final destination map, bit p = physical port p |
| outTc | output | 3 | Final traffic class (queue selector) |
| outClassId | output | 8 | Classification ID for the frame tag |

## Verification
The assertions check three things on every cycle:

- the no-hit pass-through and zero ID;
- that the traffic class is kept when the override flag is clear;
- that remove never adds a port, add never drops one, and replace never drives the skipped port.

Only the bench's scenarios can show the exact bit-to-port shift around port 6, the full results of each mode against chosen maps, and the extraction of the ID while neighbouring action bits are set. The same holds for the one-cycle alignment during back-to-back changes of every input.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  localparam int ACT_W      = 32;
  localparam int MAP_W      = 9;
  localparam int PHYS_W     = MAP_W + 1;
  localparam int SKIP_PORT  = 6;
  localparam int TC_W       = 3;
  localparam int ID_W       = 8;
  localparam int MODE_W     = 2;
  localparam int DST_LSB    = 14;
  localparam int MODE_LSB   = 24;
  localparam int TC_LSB     = 10;
  localparam int TC_CHG_BIT = 13;
  localparam int ID_LSB     = 20;

  typedef enum logic [MODE_W-1:0] {
    FWD_KEEP    = 2'd0,
    FWD_REMOVE  = 2'd1,
    FWD_REPLACE = 2'd2,
    FWD_ADD     = 2'd3
  } fwdMode_e;

  typedef struct packed {
    fwdMode_e         fwdMode;
    logic             tcChg;
    logic [TC_W-1:0]  newTc;
    logic [MAP_W-1:0] dstMap;
    logic [ID_W-1:0]  chainId;
  } actStrobe_t;
endpackage

// File: rtl/cfa_ctrl.sv
module cfa_ctrl
  import cfa_pkg::*;
(
  input  logic             hitFlag,
  input  logic [ACT_W-1:0] actWord0,
  input  logic [ACT_W-1:0] actWord1,
  output actStrobe_t       strobe
);
  // bits of the action words that this block does not act on
  logic unusedBits;
  assign unusedBits = ^{actWord0[TC_LSB-1:0], actWord0[DST_LSB+MAP_W],
                        actWord0[ACT_W-1:MODE_LSB+MODE_W],
                        actWord1[ID_LSB-1:0], actWord1[ACT_W-1:ID_LSB+ID_W]};

  // a miss turns the strobe set into a neutral pass-through
  always_comb begin
    strobe         = '0;
    strobe.fwdMode = FWD_KEEP;
    if (hitFlag) begin
      strobe.fwdMode = fwdMode_e'(actWord0[MODE_LSB +: MODE_W]);
      strobe.tcChg   = actWord0[TC_CHG_BIT];
      strobe.newTc   = actWord0[TC_LSB +: TC_W];
      strobe.dstMap  = actWord0[DST_LSB +: MAP_W];
      strobe.chainId = actWord1[ID_LSB +: ID_W];
    end
  end
endmodule

// File: rtl/cfa_datapath.sv
module cfa_datapath
  import cfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHYS_W-1:0] learnMap,
  input  logic [TC_W-1:0]   frameTc,
  input  actStrobe_t        strobe,
  output logic [PHYS_W-1:0] outMap,
  output logic [TC_W-1:0]   outTc,
  output logic [ID_W-1:0]   outClassId
);
  logic [PHYS_W-1:0] expMap;
  logic [PHYS_W-1:0] nextMap;

  // spread the compressed action map over physical ports, leaving a hole
  for (genvar p = 0; p < PHYS_W; p++) begin : g_expand
    if (p < SKIP_PORT) begin : g_low
      assign expMap[p] = strobe.dstMap[p];
    end else if (p == SKIP_PORT) begin : g_hole
      assign expMap[p] = 1'b0;
    end else begin : g_high
      assign expMap[p] = strobe.dstMap[p-1];
    end
  end

  always_comb begin
    unique case (strobe.fwdMode)
      FWD_REMOVE:  nextMap = learnMap & ~expMap;
      FWD_REPLACE: nextMap = expMap;
      FWD_ADD:     nextMap = learnMap | expMap;
      default:     nextMap = learnMap;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outMap     <= '0;
      outTc      <= '0;
      outClassId <= '0;
    end else begin
      outMap     <= nextMap;
      outTc      <= strobe.tcChg ? strobe.newTc : frameTc;
      outClassId <= strobe.chainId;
    end
  end

  AST_REMOVE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fwdMode == FWD_REMOVE) |=> ((outMap & ~$past(learnMap)) == '0)); // R5
  AST_REPLACE_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fwdMode == FWD_REPLACE) |=> !outMap[SKIP_PORT]); // R6
  AST_ADD_SUPERSET: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fwdMode == FWD_ADD) |=> ((outMap & $past(learnMap)) == $past(learnMap))); // R7
endmodule

// File: rtl/cfa_action_modifier.sv
module cfa_action_modifier
  import cfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hitFlag,
  input  logic [PHYS_W-1:0] learnMap,
  input  logic [TC_W-1:0]   frameTc,
  input  logic [ACT_W-1:0]  actWord0,
  input  logic [ACT_W-1:0]  actWord1,
  output logic [PHYS_W-1:0] outMap,
  output logic [TC_W-1:0]   outTc,
  output logic [ID_W-1:0]   outClassId
);
  actStrobe_t strobe;

  cfa_ctrl i_ctrl (
    .hitFlag  (hitFlag),
    .actWord0 (actWord0),
    .actWord1 (actWord1),
    .strobe   (strobe)
  );

  cfa_datapath i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .learnMap   (learnMap),
    .frameTc    (frameTc),
    .strobe     (strobe),
    .outMap     (outMap),
    .outTc      (outTc),
    .outClassId (outClassId)
  );

  AST_MISS_MAP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !hitFlag |=> (outMap == $past(learnMap))); // R3
  AST_MISS_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hitFlag |=> (outClassId == '0)); // R3
  AST_TC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hitFlag || !actWord0[TC_CHG_BIT]) |=> (outTc == $past(frameTc))); // R9
endmodule

// File: tb/test_cfa_action_modifier.sv
module test_cfa_action_modifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hitFlag = 1'b0;
  logic [9:0]  learnMap = '0;
  logic [2:0]  frameTc = '0;
  logic [31:0] actWord0 = '0;
  logic [31:0] actWord1 = '0;
  logic [9:0]  outMap;
  logic [2:0]  outTc;
  logic [7:0]  outClassId;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [9:0] expMapQ[$];
  logic [2:0] expTcQ[$];
  logic [7:0] expIdQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  cfa_action_modifier i_cfa_action_modifier (
    .clk(clk), .rst_n(rst_n), .hitFlag(hitFlag), .learnMap(learnMap),
    .frameTc(frameTc), .actWord0(actWord0), .actWord1(actWord1),
    .outMap(outMap), .outTc(outTc), .outClassId(outClassId)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // R8 reference: bit n -> port n below 6, port n+1 from 6 upward
  function automatic logic [9:0] spread(logic [8:0] m);
    logic [9:0] r = '0;
    for (int n = 0; n < 9; n++) begin
      if (n < 6) r[n] = m[n];
      else       r[n+1] = m[n];
    end
    return r;
  endfunction

  function automatic logic [31:0] mkW0(logic [1:0] mode, logic [8:0] map, logic chg, logic [2:0] tc);
    return {6'b0, mode, 1'b0, map, chg, tc, 10'b0};
  endfunction

  task automatic drive(logic hit, logic [9:0] lm, logic [2:0] tc,
                       logic [31:0] w0, logic [31:0] w1, string tag);
    logic [9:0] em;
    logic [9:0] am;
    @(negedge clk);
    hitFlag = hit; learnMap = lm; frameTc = tc; actWord0 = w0; actWord1 = w1;
    am = spread(w0[22:14]);
    if (!hit) em = lm;
    else case (w0[25:24])
      2'd1: em = lm & ~am;
      2'd2: em = am;
      2'd3: em = lm | am;
      default: em = lm;
    endcase
    expMapQ.push_back(em);
    expTcQ.push_back((hit && w0[13]) ? w0[12:10] : tc);
    expIdQ.push_back(hit ? w1[27:20] : 8'h00);
    tagQ.push_back(tag);
  endtask

  // monitor: compare outputs just after the edge that captured each item
  always @(posedge clk) begin
    #2;
    if (tagQ.size() > 0) begin
      string t;
      t = tagQ.pop_front();
      chk(t, "map", 32'(outMap), 32'(expMapQ.pop_front()));
      chk(t, "tc",  32'(outTc),  32'(expTcQ.pop_front()));
      chk(t, "id",  32'(outClassId), 32'(expIdQ.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hitFlag = 1'b1; learnMap = 10'h3FF; frameTc = 3'd7;
    actWord0 = 32'hFFFF_FFFF; actWord1 = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1", "map in reset", 32'(outMap), 0);
    chk("R1", "tc in reset",  32'(outTc), 0);
    chk("R1", "id in reset",  32'(outClassId), 0);
    rst_n = 1'b1;
    hitFlag = 1'b0;

    // R3: miss with busy action words
    drive(1'b0, 10'h2C5, 3'd4, mkW0(2'd2, 9'h1FF, 1'b1, 3'd1), 32'hFFFF_FFFF, "R3");
    // R4: keep mode
    drive(1'b1, 10'h155, 3'd2, mkW0(2'd0, 9'h0F3, 1'b0, 3'd0), 32'h0010_0000, "R4");
    // R5: remove
    drive(1'b1, 10'h3FF, 3'd1, mkW0(2'd1, 9'h1A5, 1'b0, 3'd6), 32'h0, "R5");
    // R6 / R8: replace, port 6 learned but dropped
    drive(1'b1, 10'h040, 3'd0, mkW0(2'd2, 9'h1FF, 1'b0, 3'd0), 32'h0, "R6");
    // R7 / R8: add, map bit 6 lands on port 7
    drive(1'b1, 10'h040, 3'd0, mkW0(2'd3, 9'h040, 1'b0, 3'd0), 32'h0, "R7");
    // R8: map bit 5 stays on port 5, map bit 8 goes to port 9
    drive(1'b1, 10'h000, 3'd0, mkW0(2'd2, 9'h120, 1'b0, 3'd0), 32'h0, "R8");
    // R9: override on, then field set but flag off
    drive(1'b1, 10'h001, 3'd2, mkW0(2'd0, 9'h000, 1'b1, 3'd5), 32'h0, "R9");
    drive(1'b1, 10'h001, 3'd2, mkW0(2'd0, 9'h000, 1'b0, 3'd7), 32'h0, "R9");
    // R10: ID with all neighbouring bits set
    drive(1'b1, 10'h00F, 3'd3, mkW0(2'd0, 9'h000, 1'b0, 3'd0), 32'hFA5F_FFFF, "R10");
    drive(1'b1, 10'h00F, 3'd3, mkW0(2'd0, 9'h000, 1'b0, 3'd0), 32'h000F_FFFF, "R10");
    // R2: back-to-back random traffic
    for (int i = 0; i < 200; i++) begin
      drive(1'($urandom), 10'($urandom), 3'($urandom), $urandom, $urandom, "R2");
    end
    @(negedge clk);
    hitFlag = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule